// File: doc/BRIEF.md
# Watchdog and Interval Timer with Committed Configuration

This block measures time from the system clock and either resets the chip or interrupts it when software stops checking in. A fixed two-stage pre-divider turns the clock into a base tick. A power-of-two prescaler selected by a 3-bit field slows that tick further. The slowed tick decrements an 8-bit counter. The counter is reloaded from a software value W. It expires after W+1 prescaled ticks. In watchdog mode an expiry pulses a reset request for one cycle. In interval mode it sets a sticky overflow flag and the counter starts its next period on its own.

Software writes to the mode and prescaler fields land in a pending (user) copy. The timing logic runs from an active copy, and the pending copy is moved into it only by a valid feed. A feed is a two-byte key written to the feed register. Stray code therefore cannot retune or disable the watchdog with a single register write. A lock strap can pin the mode and prescaler to strap inputs. While the lock is in force, the straps drive the timing logic directly and software writes to those fields are discarded.

Register map (select codes on `wr_sel` and `rd_sel`): 0 = control, 1 = reload, 2 = feed (reads as zero). Control byte: bit 7 = mode (1 watchdog, 0 interval), bit 6 = run, bit 5 = overflow flag, bits 2:0 = prescaler select; bits 4:3 read as zero.

Top module: `wdog_shadow`

## Requirements
- R1: After reset the control register reads 00h, the reload register reads 00h, and both `wdt_rst_req` and `tmr_irq` are low.
- R2: With base divide D = PREDIV*BASEDIV, prescaler select P and reload W, an expiry becomes visible D*2^P*(W+1) clock edges after the edge that starts the count: the feed edge, or the edge that sets run when run was clear.
- R3: A feed occurs only when a feed-register write of A5h is followed, on the next feed-register write, by 5Ah. Any other second byte (including A5h again) cancels the sequence without a feed, and 5Ah without a preceding A5h does nothing.
- R4: A feed reloads the main counter from W and clears the whole pre-divider and prescaler chain, so the full timeout restarts from the feed edge.
- R5: Control writes change the mode and prescaler values that read back at once. The timing logic keeps using the previous mode and prescaler until the next feed copies the pending values across.
- R6: In watchdog mode (bit 7 = 1) an expiry raises `wdt_rst_req` for exactly one cycle and leaves the overflow flag clear.
- R7: In interval mode (bit 7 = 0) an expiry sets the flag (bit 5, `tmr_irq`), never raises `wdt_rst_req`, and reloads the counter so that the next expiry follows one period later. The flag stays set until a control write with bit 5 = 0. An expiry in the same cycle as such a write leaves the flag set.
- R8: While the active run bit (bit 6) is clear, the counter and the divider chain hold their state, and no expiry occurs.
- R9: While `strap_lock` is high, the mode and prescaler come from `strap_mode` and `strap_psel`, both for timing and on read-back. Control writes leave the pending mode and prescaler unchanged; they read back as before once the lock is released.
- R10: While locked in watchdog mode the run bit reads 1, the block runs, and run writes are ignored. While locked in interval mode the run bit can be written as usual.
- R11: The reload register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 control, 1 reload, 2 feed |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Read target: 0 control, 1 reload, 2 feed |
| rd_data | output | 8 | Combinational read data for `rd_sel` |
| strap_lock | input | 1 | Pins mode and prescaler to the strap inputs |
| strap_mode | input | 1 | Strapped mode, 1 = watchdog |
| strap_psel | input | PSEL_W | Strapped prescaler select |
| wdt_rst_req | output | 1 | One-cycle reset request on watchdog expiry |
| tmr_irq | output | 1 | Sticky interval overflow flag |

## Verification
Both expiry outputs are registered. They become visible exactly D*2^P*(W+1) edges after the edge that started the count. Register writes and the feed take effect on the edge of their write, and read data is combinational, so a write is visible at the next falling edge. The bench drives inputs and samples outputs only on falling edges. It keeps a free-running count of rising edges and stamps the start edge of each count. It then compares the edge count at which an output first appears against the formula, so an expiry that arrives one cycle early or late is caught. The single-cycle reset pulse and the flag clear are checked at the next falling edge after the event or the write.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int DATA_W = 8;

  // register select codes
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_FEED   = 2'd2;

  // control byte bit positions
  localparam int MODE_BIT = 7;
  localparam int RUN_BIT  = 6;
  localparam int FLAG_BIT = 5;

  // feed key bytes
  localparam logic [DATA_W-1:0] FEED_KEY_A = 8'hA5;
  localparam logic [DATA_W-1:0] FEED_KEY_B = 8'h5A;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_st_e;
endpackage

// File: rtl/wdog_modctr.sv
`timescale 1ns/1ps
// Modulo-MOD divider stage: wrap pulses on the enabled cycle that completes MOD counts.
module wdog_modctr #(
  parameter int MOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic wrap
);
  generate
    if (MOD > 1) begin : g_cnt
      localparam int CW = $clog2(MOD);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_top;

      assign at_top = (cnt_q == CW'(MOD - 1));

      always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
          cnt_d = '0;
        end else if (en) begin
          cnt_d = at_top ? '0 : cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign wrap = en && at_top;
    end else begin : g_pass
      logic unused_pass;
      assign unused_pass = &{1'b0, clk, rst_n, clr};
      assign wrap = en;
    end
  endgenerate
endmodule

// File: rtl/wdog_tick_chain.sv
`timescale 1ns/1ps
// Fixed pre-divider, base divider and selectable power-of-two prescaler.
module wdog_tick_chain #(
  parameter int PREDIV  = 12,
  parameter int BASEDIV = 64,
  parameter int PSEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel,
  output logic              ps_tick
);
  localparam int PS_W = (1 << PSEL_W) - 1;

  logic            div_tick;
  logic            base_tick;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_d;
  logic [PS_W-1:0] ps_mask;

  wdog_modctr #(.MOD(PREDIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .clr  (clr),
    .wrap (div_tick)
  );

  wdog_modctr #(.MOD(BASEDIV)) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (div_tick),
    .clr  (clr),
    .wrap (base_tick)
  );

  // low P bits of the ripple counter must all be one for a prescaled tick
  always_comb begin
    ps_mask = ~({PS_W{1'b1}} << psel);
    ps_d    = ps_q;
    if (clr) begin
      ps_d = '0;
    end else if (base_tick) begin
      ps_d = ps_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else begin
      ps_q <= ps_d;
    end
  end

  assign ps_tick = base_tick && ((ps_q & ps_mask) == ps_mask);
endmodule

// File: rtl/wdog_feed_seq.sv
`timescale 1ns/1ps
// Two-byte feed key detector.
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feed_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic              feed_pulse
);
  feed_st_e st_q;
  feed_st_e st_d;

  always_comb begin
    st_d       = st_q;
    feed_pulse = 1'b0;
    if (feed_we) begin
      unique case (st_q)
        FEED_IDLE: begin
          if (wr_data == FEED_KEY_A) begin
            st_d = FEED_ARMED;
          end
        end
        FEED_ARMED: begin
          st_d       = FEED_IDLE;
          feed_pulse = (wr_data == FEED_KEY_B);
        end
        default: st_d = FEED_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FEED_IDLE;
    end else begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/wdog_cfg_regs.sv
`timescale 1ns/1ps
// Pending and active configuration, run bit, reload value and overflow flag.
module wdog_cfg_regs
  import wdog_pkg::*;
#(
  parameter int PSEL_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              reload_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              feed,
  input  logic              set_flag,
  input  logic              strap_lock,
  input  logic              strap_mode,
  input  logic [PSEL_W-1:0] strap_psel,
  output logic              act_mode,
  output logic [PSEL_W-1:0] act_psel,
  output logic              act_run,
  output logic [CNT_W-1:0]  reload_val,
  output logic              flag,
  output logic [DATA_W-1:0] ctrl_rd
);
  logic              usr_mode_q, usr_mode_d;
  logic [PSEL_W-1:0] usr_psel_q, usr_psel_d;
  logic              act_mode_q, act_mode_d;
  logic [PSEL_W-1:0] act_psel_q, act_psel_d;
  logic              run_q, run_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic              flag_q, flag_d;
  logic              run_locked;

  assign run_locked = strap_lock && strap_mode;

  always_comb begin
    usr_mode_d = usr_mode_q;
    usr_psel_d = usr_psel_q;
    if (ctrl_we && !strap_lock) begin
      usr_mode_d = wr_data[MODE_BIT];
      usr_psel_d = wr_data[PSEL_W-1:0];
    end

    act_mode_d = act_mode_q;
    act_psel_d = act_psel_q;
    if (feed) begin
      act_mode_d = usr_mode_q;
      act_psel_d = usr_psel_q;
    end

    run_d = run_q;
    if (ctrl_we && !run_locked) begin
      run_d = wr_data[RUN_BIT];
    end

    reload_d = reload_q;
    if (reload_we) begin
      reload_d = wr_data[CNT_W-1:0];
    end

    flag_d = flag_q;
    if (set_flag) begin
      flag_d = 1'b1;
    end else if (ctrl_we && !wr_data[FLAG_BIT]) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_mode_q <= 1'b0;
      usr_psel_q <= '0;
      act_mode_q <= 1'b0;
      act_psel_q <= '0;
      run_q      <= 1'b0;
      reload_q   <= '0;
      flag_q     <= 1'b0;
    end else begin
      usr_mode_q <= usr_mode_d;
      usr_psel_q <= usr_psel_d;
      act_mode_q <= act_mode_d;
      act_psel_q <= act_psel_d;
      run_q      <= run_d;
      reload_q   <= reload_d;
      flag_q     <= flag_d;
    end
  end

  assign act_mode   = strap_lock ? strap_mode : act_mode_q;
  assign act_psel   = strap_lock ? strap_psel : act_psel_q;
  assign act_run    = run_locked ? 1'b1 : run_q;
  assign reload_val = reload_q;
  assign flag       = flag_q;

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[MODE_BIT]      = strap_lock ? strap_mode : usr_mode_q;
    ctrl_rd[RUN_BIT]       = act_run;
    ctrl_rd[FLAG_BIT]      = flag_q;
    ctrl_rd[PSEL_W-1:0]    = strap_lock ? strap_psel : usr_psel_q;
  end
endmodule

// File: rtl/wdog_main_cnt.sv
`timescale 1ns/1ps
// Reloadable down-counter with expiry decode.
module wdog_main_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             wd_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             set_flag,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             expire;

  assign expire = tick && !load && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = reload_val;
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
    end
    req_d = expire && wd_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt      = cnt_q;
  assign set_flag = expire && !wd_mode;
  assign rst_req  = req_q;
endmodule

// File: rtl/wdog_shadow.sv
`timescale 1ns/1ps
module wdog_shadow
  import wdog_pkg::*;
#(
  parameter int PREDIV  = 12,
  parameter int BASEDIV = 64,
  parameter int PSEL_W  = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_sel,
  output logic [7:0]        rd_data,
  input  logic              strap_lock,
  input  logic              strap_mode,
  input  logic [PSEL_W-1:0] strap_psel,
  output logic              wdt_rst_req,
  output logic              tmr_irq
);
  logic              rst_meta_q, rst_sync_n;
  logic              ctrl_we, reload_we, feed_we;
  logic              feed_pulse;
  logic              act_mode, act_run;
  logic [PSEL_W-1:0] act_psel;
  logic [CNT_W-1:0]  reload_val;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] ctrl_rd;
  logic              ps_tick;
  logic              set_flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign ctrl_we   = wr_en && (wr_sel == SEL_CTRL);
  assign reload_we = wr_en && (wr_sel == SEL_RELOAD);
  assign feed_we   = wr_en && (wr_sel == SEL_FEED);

  wdog_feed_seq u_feed (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .feed_we   (feed_we),
    .wr_data   (wr_data),
    .feed_pulse(feed_pulse)
  );

  wdog_cfg_regs #(.PSEL_W(PSEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_we   (ctrl_we),
    .reload_we (reload_we),
    .wr_data   (wr_data),
    .feed      (feed_pulse),
    .set_flag  (set_flag),
    .strap_lock(strap_lock),
    .strap_mode(strap_mode),
    .strap_psel(strap_psel),
    .act_mode  (act_mode),
    .act_psel  (act_psel),
    .act_run   (act_run),
    .reload_val(reload_val),
    .flag      (tmr_irq),
    .ctrl_rd   (ctrl_rd)
  );

  wdog_tick_chain #(.PREDIV(PREDIV), .BASEDIV(BASEDIV), .PSEL_W(PSEL_W)) u_chain (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (act_run),
    .clr    (feed_pulse),
    .psel   (act_psel),
    .ps_tick(ps_tick)
  );

  wdog_main_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (ps_tick),
    .load      (feed_pulse),
    .reload_val(reload_val),
    .wd_mode   (act_mode),
    .cnt       (cnt_q),
    .set_flag  (set_flag),
    .rst_req   (wdt_rst_req)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_CTRL:   rd_data = ctrl_rd;
      SEL_RELOAD: rd_data[CNT_W-1:0] = reload_val;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_shadow_chk.sv
`timescale 1ns/1ps
module wdog_shadow_chk
  import wdog_pkg::*;
#(
  parameter int PREDIV  = 12,
  parameter int BASEDIV = 64,
  parameter int PSEL_W  = 3,
  parameter int CNT_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [7:0]        wr_data,
  input logic [1:0]        rd_sel,
  input logic [7:0]        rd_data,
  input logic              strap_lock,
  input logic              strap_mode,
  input logic [PSEL_W-1:0] strap_psel,
  input logic              wdt_rst_req,
  input logic              tmr_irq,
  input logic              feed_pulse,
  input logic              act_mode,
  input logic [PSEL_W-1:0] act_psel,
  input logic              act_run,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload_val
);
  localparam int BASE_D = PREDIV * BASEDIV;

  // R4: a feed loads the counter from the reload register
  a_r4_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    feed_pulse |=> (cnt == $past(reload_val)));

  // R5: without a feed the active configuration does not move
  a_r5_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_pulse && !strap_lock) |=>
      (strap_lock || (act_mode == $past(act_mode) && act_psel == $past(act_psel))));

  // R6: the reset request only follows a watchdog-mode expiry
  a_r6_req_needs_wd: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(act_mode));

  generate
    if (BASE_D > 1) begin : g_pulse
      // R6: the reset request lasts a single cycle
      a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);
    end
  endgenerate

  // R7: the flag stays set unless software clears it
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq && !(wr_en && wr_sel == SEL_CTRL && !wr_data[FLAG_BIT])) |=> tmr_irq);

  // R8: a stopped block keeps its count
  a_r8_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_run && !feed_pulse) |=> $stable(cnt));

  // R9: locked read-back shows the straps
  a_r9_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_lock && rd_sel == SEL_CTRL) |->
      (rd_data[MODE_BIT] == strap_mode && rd_data[PSEL_W-1:0] == strap_psel));

  // R10: locked watchdog runs and reads run as one
  a_r10_run_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_lock && strap_mode) |-> (act_run && (rd_sel != SEL_CTRL || rd_data[RUN_BIT])));
endmodule

bind wdog_shadow wdog_shadow_chk #(
  .PREDIV (PREDIV),
  .BASEDIV(BASEDIV),
  .PSEL_W (PSEL_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .strap_lock (strap_lock),
  .strap_mode (strap_mode),
  .strap_psel (strap_psel),
  .wdt_rst_req(wdt_rst_req),
  .tmr_irq    (tmr_irq),
  .feed_pulse (feed_pulse),
  .act_mode   (act_mode),
  .act_psel   (act_psel),
  .act_run    (act_run),
  .cnt        (cnt_q),
  .reload_val (reload_val)
);

// File: tb/sim_wdog_shadow.sv
`timescale 1ns/1ps
module sim_wdog_shadow;
  import wdog_pkg::*;

  localparam int PRE = 3;
  localparam int BAS = 2;
  localparam int D   = PRE * BAS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic       strap_lock;
  logic       strap_mode;
  logic [2:0] strap_psel;
  logic       wdt_rst_req;
  logic       tmr_irq;

  int cyc   = 0;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_shadow #(.PREDIV(PRE), .BASEDIV(BAS), .PSEL_W(3), .CNT_W(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .strap_lock (strap_lock),
    .strap_mode (strap_mode),
    .strap_psel (strap_psel),
    .wdt_rst_req(wdt_rst_req),
    .tmr_irq    (tmr_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_sel  = s;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic feed();
    wr(SEL_FEED, 8'hA5);
    wr(SEL_FEED, 8'h5A);
  endtask

  function automatic logic [7:0] cb(input logic m, input logic r, input logic [2:0] p);
    return {m, r, 1'b0, 2'b00, p};
  endfunction

  task automatic wait_evt(input bit on_req, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      if (on_req ? wdt_rst_req : tmr_irq) begin
        t = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  // stopped setup, feed to commit, then start; ts is the start edge
  task automatic start_cfg(input logic m, input logic [2:0] p, input logic [7:0] w, output int ts);
    wr(SEL_CTRL, cb(m, 1'b0, p));
    wr(SEL_RELOAD, w);
    feed();
    wr(SEL_CTRL, cb(m, 1'b1, p));
    ts = cyc;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int ts, t, n, e1, e2;

    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    strap_lock = 1'b0; strap_mode = 1'b0; strap_psel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rdreg(SEL_CTRL, v);   chk("R1 control", v, 0);
    rdreg(SEL_RELOAD, v); chk("R1 reload", v, 0);
    chk("R1 req", wdt_rst_req, 0);
    chk("R1 irq", tmr_irq, 0);

    // R8: stopped after reset, nothing expires
    repeat (40) @(negedge clk);
    chk("R8 idle irq", tmr_irq, 0);
    chk("R8 idle req", wdt_rst_req, 0);

    // R2, R6, R7, R11: sweep mode, prescaler and reload
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int wi = 0; wi < 3; wi++) begin
          int w;
          w = (wi == 0) ? 0 : ((wi == 1) ? 2 : 5);
          n = D * (1 << p) * (w + 1);
          start_cfg(m[0], p[2:0], w[7:0], ts);
          rdreg(SEL_RELOAD, v);
          chk($sformatf("R11 reload %0d", w), v, w);
          if (m == 1) begin
            wait_evt(1'b1, 4 * n + 20, t);
            chk($sformatf("R2 wd timeout p=%0d w=%0d", p, w), t - ts, n);
            chk("R6 no flag in watchdog", tmr_irq, 0);
            @(negedge clk);
            chk("R6 single-cycle request", wdt_rst_req, 0);
          end else begin
            wait_evt(1'b0, 4 * n + 20, t);
            chk($sformatf("R2 timer timeout p=%0d w=%0d", p, w), t - ts, n);
            chk("R7 no request in timer", wdt_rst_req, 0);
            wr(SEL_CTRL, cb(1'b0, 1'b1, p[2:0]));
            chk("R7 flag cleared", tmr_irq, 0);
            wait_evt(1'b0, 4 * n + 20, t);
            chk($sformatf("R7 auto-reload p=%0d w=%0d", p, w), t - ts, 2 * n);
          end
        end
      end
    end

    // R2: largest prescaler
    start_cfg(1'b1, 3'd7, 8'd1, ts);
    wait_evt(1'b1, 4000, t);
    chk("R2 prescaler 7", t - ts, D * 128 * 2);

    // R3 and R4: feed key handling, watchdog P=0 W=3 -> 24 edges
    start_cfg(1'b1, 3'd0, 8'd3, ts);
    wr(SEL_FEED, 8'hA5); wr(SEL_FEED, 8'h11); wr(SEL_FEED, 8'h5A);
    wait_evt(1'b1, 200, t);
    chk("R3 wrong second byte aborts", t - ts, 24);
    start_cfg(1'b1, 3'd0, 8'd3, ts);
    wr(SEL_FEED, 8'hA5); wr(SEL_FEED, 8'hA5); wr(SEL_FEED, 8'h5A);
    wait_evt(1'b1, 200, t);
    chk("R3 repeated A5h aborts", t - ts, 24);
    start_cfg(1'b1, 3'd0, 8'd3, ts);
    repeat (5) @(negedge clk);
    feed();
    ts = cyc;
    wait_evt(1'b1, 200, t);
    chk("R4 valid feed restarts timeout", t - ts, 24);

    // R5: pending prescaler not used until a feed
    wr(SEL_CTRL, cb(1'b0, 1'b0, 3'd0));
    wr(SEL_RELOAD, 8'd1);
    feed();
    wr(SEL_CTRL, cb(1'b0, 1'b0, 3'd2));
    rdreg(SEL_CTRL, v);
    chk("R5 pending psel reads back", v[2:0], 2);
    wr(SEL_CTRL, cb(1'b0, 1'b1, 3'd2));
    ts = cyc;
    wait_evt(1'b0, 200, t);
    chk("R5 old prescaler still active", t - ts, 12);
    wr(SEL_CTRL, cb(1'b0, 1'b0, 3'd2));
    feed();
    wr(SEL_CTRL, cb(1'b0, 1'b1, 3'd2));
    ts = cyc;
    wait_evt(1'b0, 400, t);
    chk("R5 prescaler committed by feed", t - ts, 48);

    // R5: pending mode not used until a feed
    wr(SEL_CTRL, cb(1'b0, 1'b0, 3'd0));
    feed();
    wr(SEL_CTRL, cb(1'b1, 1'b0, 3'd0));
    wr(SEL_CTRL, cb(1'b1, 1'b1, 3'd0));
    ts = cyc;
    wait_evt(1'b0, 200, t);
    chk("R5 old mode gives flag", t - ts, 12);
    chk("R5 old mode no request", wdt_rst_req, 0);
    wr(SEL_CTRL, cb(1'b1, 1'b0, 3'd0));
    feed();
    wr(SEL_CTRL, cb(1'b1, 1'b1, 3'd0));
    ts = cyc;
    wait_evt(1'b1, 200, t);
    chk("R5 committed mode gives request", t - ts, 12);

    // R8: stopping mid-count freezes the timeout
    start_cfg(1'b1, 3'd1, 8'd1, ts);
    repeat (4) @(negedge clk);
    wr(SEL_CTRL, cb(1'b1, 1'b0, 3'd1));
    e1 = cyc;
    repeat (30) @(negedge clk);
    chk("R8 stopped no request", wdt_rst_req, 0);
    wr(SEL_CTRL, cb(1'b1, 1'b1, 3'd1));
    e2 = cyc;
    wait_evt(1'b1, 200, t);
    chk("R8 count resumes", t - ts, 24 + (e2 - e1));

    // R9, R10: locked in watchdog mode
    wr(SEL_CTRL, cb(1'b0, 1'b0, 3'd0));
    strap_psel = 3'd1; strap_mode = 1'b1; strap_lock = 1'b1;
    rdreg(SEL_CTRL, v);
    chk("R9 R10 locked read-back", v & 8'hC7, 8'hC1);
    wr(SEL_CTRL, 8'h03);
    rdreg(SEL_CTRL, v);
    chk("R9 R10 locked write ignored", v & 8'hC7, 8'hC1);
    wr(SEL_RELOAD, 8'd1);
    feed();
    ts = cyc;
    wait_evt(1'b1, 200, t);
    chk("R9 strap prescaler timing", t - ts, 24);

    // R10: locked in timer mode, run writable
    strap_mode = 1'b0;
    rdreg(SEL_CTRL, v);
    chk("R10 timer lock run keeps written 0", v[6], 0);
    wr(SEL_CTRL, 8'h00);
    feed();
    wr(SEL_CTRL, 8'h40);
    ts = cyc;
    rdreg(SEL_CTRL, v);
    chk("R10 timer lock run writable", v & 8'hC7, 8'h41);
    wait_evt(1'b0, 200, t);
    chk("R9 timer lock timing", t - ts, 24);

    // R9: pending fields untouched by locked writes
    strap_lock = 1'b0;
    rdreg(SEL_CTRL, v);
    chk("R9 pending fields after unlock", v & 8'hC7, 8'h40);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule